// File: doc/BRIEF.md
# Charge Threshold Alert Controller

This block watches a 16-bit accumulated charge value against a programmable upper and lower limit and records each violation in a sticky status flag. A battery-voltage-low comparator input is synchronized and recorded in a third flag. All three flags hold until software reads the status, which the register bus signals with a one-cycle read-clear strobe.

A single open-drain pad is shared between two uses, chosen by a 2-bit mode field. In alert use the block pulls the pad low while any flag is set. In charge-complete use the pad is an input: its synchronized rising edge produces a one-cycle strobe that presets the external charge accumulator to full scale. The two limit registers live here and are loaded through write-enable and data inputs. The register bus that drives them is outside this block.

Top module: `charge_alert_ctrl`

## Requirements
- R1: After reset status_o is 000, pin_pd_o and cc_preset_o are 0, the upper limit is FFFFh and the lower limit is 0000h, so no charge value sets a limit flag.
- R2: status_o bit 2 (high flag) is set on the clock edge that samples charge_i strictly greater than the upper limit. A charge equal to the limit does not set it.
- R3: status_o bit 0 (low flag) is set on the clock edge that samples charge_i strictly less than the lower limit. A charge equal to the limit does not set it.
- R4: status_o bit 1 (voltage-low flag) is set when vlow_i is high after a two-stage synchronizer. It is visible no later than three clock edges after vlow_i rises.
- R5: A set flag stays set until stat_rd_i is sampled high. The clock edge that samples stat_rd_i clears every flag whose condition is absent in that cycle. A flag whose condition is present in that cycle stays set, because setting wins over clearing.
- R6: With mode_i = 2'b10 (alert), pin_pd_o is high whenever any flag is set. It is released once all flags are cleared.
- R7: With mode_i = 2'b00, 2'b01 or 2'b11, pin_pd_o stays low regardless of the flags.
- R8: With mode_i = 2'b01 (charge-complete), a rising edge of pin_i gives exactly one cycle of cc_preset_o. The pulse comes in the second cycle after the first clock edge that sees the pad high. A pad held high gives no further pulse.
- R9: With mode_i = 2'b00, 2'b10 or 2'b11, pad edges never assert cc_preset_o.
- R10: thr_hi_we_i loads thr_wdata_i into the upper limit and thr_lo_we_i loads it into the lower limit. The new limit governs the comparison from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| charge_i | input | 16 | Accumulated charge value |
| thr_hi_we_i | input | 1 | Load upper limit |
| thr_lo_we_i | input | 1 | Load lower limit |
| thr_wdata_i | input | 16 | Limit write data |
| mode_i | input | 2 | Pad mode: 00 off, 10 alert, 01 charge-complete, 11 reserved (off) |
| vlow_i | input | 1 | Battery-voltage-low comparator output (asynchronous) |
| pin_i | input | 1 | Sampled pad level (asynchronous) |
| stat_rd_i | input | 1 | Status read-clear strobe |
| status_o | output | 3 | Flags: bit 2 high, bit 1 voltage-low, bit 0 low |
| pin_pd_o | output | 1 | Pad pull-down enable |
| cc_preset_o | output | 1 | Preset charge accumulator to full |

## Verification
The bench places the charge exactly on each limit, because a design that used inclusive comparison would raise a flag there. It clears the status while a limit condition still holds, and expects the flag to survive; a design where clearing wins would drop a live alarm. It holds the pad high in charge-complete mode and counts strobes, which catches a level-sensitive detector that keeps presetting the counter. It drives the reserved mode with flags set and with pad edges, so a decoder that treated 11 as alert or as charge-complete would either pull the pad or fire the preset strobe.

// File: rtl/cta_pkg.sv
package cta_pkg;
  localparam int unsigned STAT_W  = 3;
  localparam int unsigned ST_LOW  = 0;
  localparam int unsigned ST_VLOW = 1;
  localparam int unsigned ST_HIGH = 2;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_CC    = 2'b01,
    MODE_ALERT = 2'b10,
    MODE_RSVD  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/cta_sync.sv
module cta_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cta_thresh.sv
module cta_thresh #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] charge_i,
  input  logic          hi_we_i,
  input  logic          lo_we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] thr_hi_o,
  output logic [CW-1:0] thr_lo_o,
  output logic          above_o,
  output logic          below_o
);
  logic [CW-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '1;
      lo_q <= '0;
    end else begin
      if (hi_we_i) hi_q <= wdata_i;
      if (lo_we_i) lo_q <= wdata_i;
    end
  end

  assign above_o  = charge_i > hi_q;
  assign below_o  = charge_i < lo_q;
  assign thr_hi_o = hi_q;
  assign thr_lo_o = lo_q;
endmodule

// File: rtl/cta_flags.sv
module cta_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // set has priority over read-clear so a live condition is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~{N{clr_i}}) | set_i;
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i) |=> flag_q[i]);
    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/charge_alert_ctrl.sv
module charge_alert_ctrl
  import cta_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     charge_i,
  input  logic              thr_hi_we_i,
  input  logic              thr_lo_we_i,
  input  logic [CW-1:0]     thr_wdata_i,
  input  logic [1:0]        mode_i,
  input  logic              vlow_i,
  input  logic              pin_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              pin_pd_o,
  output logic              cc_preset_o
);
  pin_mode_e         mode;
  logic [1:0]        sync_d, sync_q;
  logic              vlow_s, pin_s, pin_prev_q;
  logic              above, below;
  logic [CW-1:0]     thr_hi, thr_lo;
  logic [STAT_W-1:0] set_vec, flags;
  logic              alert_en, cc_en;

  assign mode     = pin_mode_e'(mode_i);
  assign alert_en = (mode == MODE_ALERT);
  assign cc_en    = (mode == MODE_CC);

  assign sync_d = {pin_i, vlow_i};

  cta_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );
  assign vlow_s = sync_q[0];
  assign pin_s  = sync_q[1];

  cta_thresh #(.CW(CW)) u_thresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .charge_i(charge_i),
    .hi_we_i (thr_hi_we_i),
    .lo_we_i (thr_lo_we_i),
    .wdata_i (thr_wdata_i),
    .thr_hi_o(thr_hi),
    .thr_lo_o(thr_lo),
    .above_o (above),
    .below_o (below)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_HIGH] = above;
    set_vec[ST_VLOW] = vlow_s;
    set_vec[ST_LOW]  = below;
  end

  cta_flags #(.N(STAT_W)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (stat_rd_i),
    .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev_q <= 1'b0;
    else         pin_prev_q <= pin_s;
  end

  assign status_o    = flags;
  assign pin_pd_o    = alert_en & (|flags);
  assign cc_preset_o = cc_en & pin_s & ~pin_prev_q;

  assert_hi_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_i > thr_hi) |=> status_o[ST_HIGH]);
  assert_lo_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_i < thr_lo) |=> status_o[ST_LOW]);
  assert_cc_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_preset_o |=> !cc_preset_o);
endmodule

// File: tb/tb_charge_alert_ctrl.sv
module tb_charge_alert_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] charge = 16'h7FFF;
  logic        hi_we = 0, lo_we = 0;
  logic [15:0] wdata = 0;
  logic [1:0]  mode = 2'b00;
  logic        vlow = 0, pin = 0, rd = 0;
  logic [2:0]  status;
  logic        pd, ccp;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  charge_alert_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .charge_i(charge),
    .thr_hi_we_i(hi_we), .thr_lo_we_i(lo_we), .thr_wdata_i(wdata),
    .mode_i(mode), .vlow_i(vlow), .pin_i(pin), .stat_rd_i(rd),
    .status_o(status), .pin_pd_o(pd), .cc_preset_o(ccp)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(logic [15:0] c, logic [15:0] h,
                                          logic [15:0] l, logic v);
    return {c > h, v, c < l};
  endfunction

  function automatic logic exp_pd(logic [1:0] m, logic [2:0] s);
    return (m == 2'b10) && (s != 3'b000);
  endfunction

  task automatic set_thr(logic [15:0] h, logic [15:0] l);
    wdata = h; hi_we = 1; tick(); hi_we = 0;
    wdata = l; lo_we = 1; tick(); lo_we = 0;
  endtask

  task automatic clear();
    rd = 1; tick(); rd = 0;
  endtask

  initial begin
    logic [15:0] h, l, c;
    int pulses;
    void'($urandom(32'h5EED_2941));
    @(negedge clk);
    chk("R1 status in reset", {13'd0, status}, 16'h0);
    rst_n = 1;
    tick();
    chk("R1 status", {13'd0, status}, 16'h0);
    chk("R1 pd", {15'd0, pd}, 16'h0);
    chk("R1 cc", {15'd0, ccp}, 16'h0);
    // defaults: extreme charges set nothing
    mode = 2'b10;
    charge = 16'hFFFF; tick(); tick();
    chk("R1 default high limit", {13'd0, status}, 16'h0);
    charge = 16'h0000; tick(); tick();
    chk("R1 default low limit", {13'd0, status}, 16'h0);
    chk("R1 pd idle", {15'd0, pd}, 16'h0);

    // equality boundaries
    set_thr(16'h9000, 16'h1000);
    charge = 16'h9000; clear();
    chk("R2 equal no high", {13'd0, status}, 16'h0);
    charge = 16'h1000; clear();
    chk("R3 equal no low", {13'd0, status}, 16'h0);
    charge = 16'h9001; tick();
    chk("R2 one above", {13'd0, status}, 16'h4);
    chk("R6 pd on", {15'd0, pd}, 16'h1);
    // sticky and set-wins
    charge = 16'h9001; clear();
    chk("R5 set wins over clear", {13'd0, status}, 16'h4);
    charge = 16'h5000; tick(); tick();
    chk("R5 sticky after return", {13'd0, status}, 16'h4);
    clear();
    chk("R5 cleared", {13'd0, status}, 16'h0);
    chk("R6 pd released", {15'd0, pd}, 16'h0);
    charge = 16'h0FFF; tick();
    chk("R3 one below", {13'd0, status}, 16'h1);
    // modes without pull-down
    mode = 2'b00; tick();
    chk("R7 mode 00 no pd", {15'd0, pd}, 16'h0);
    mode = 2'b01; tick();
    chk("R7 mode 01 no pd", {15'd0, pd}, 16'h0);
    mode = 2'b11; tick();
    chk("R7 mode 11 no pd", {15'd0, pd}, 16'h0);
    charge = 16'h5000; clear();

    // voltage-low
    mode = 2'b10;
    vlow = 1; tick(); tick(); tick();
    chk("R4 vlow flag", {13'd0, status}, 16'h2);
    chk("R6 pd vlow", {15'd0, pd}, 16'h1);
    vlow = 0; tick(); tick(); tick();
    chk("R4 vlow sticky", {13'd0, status}, 16'h2);
    clear();
    chk("R5 vlow cleared", {13'd0, status}, 16'h0);

    // charge-complete strobe
    mode = 2'b01;
    pin = 1; tick();
    chk("R8 no pulse yet", {15'd0, ccp}, 16'h0);
    tick();
    chk("R8 pulse", {15'd0, ccp}, 16'h1);
    tick();
    chk("R8 pulse ends", {15'd0, ccp}, 16'h0);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin tick(); pulses += ccp; end
    chk("R8 held high no repeat", pulses[15:0], 16'h0);
    pin = 0; tick(); tick(); tick();
    pin = 1; pulses = 0;
    for (int i = 0; i < 6; i++) begin tick(); pulses += ccp; end
    chk("R8 second edge one pulse", pulses[15:0], 16'h1);
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      mode = m[1:0]; pin = 0; tick(); tick(); tick();
      pin = 1; pulses = 0;
      for (int i = 0; i < 6; i++) begin tick(); pulses += ccp; end
      chk("R9 no strobe outside cc", pulses[15:0], 16'h0);
    end
    pin = 0;
    for (int i = 0; i < 4; i++) tick();
    clear();

    // random limits, charges and modes
    for (int it = 0; it < 400; it++) begin
      h = 16'($urandom); l = 16'($urandom);
      case ($urandom_range(0, 3))
        0: c = h + 16'($urandom_range(0, 2)) - 16'd1;
        1: c = l + 16'($urandom_range(0, 2)) - 16'd1;
        default: c = 16'($urandom);
      endcase
      mode = 2'($urandom);
      set_thr(h, l);
      charge = c; clear();
      chk("R10 R2 R3 random flags", {13'd0, status}, {13'd0, exp_stat(c, h, l, 1'b0)});
      chk("R6 R7 random pd", {15'd0, pd}, {15'd0, exp_pd(mode, exp_stat(c, h, l, 1'b0))});
    end
    summary();
    $finish;
  end
endmodule